// File: doc/BRIEF.md
# Pipelined byte-writable burst SRAM

A synchronous single-port memory of 18-bit words with a built-in four-beat burst address sequencer. Every input except the output enable is captured by a rising-edge register. The captured values are decoded during the following cycle into one access: an idle cycle, a read or a write. The access completes at the next edge. Read data leaves through an output register, so it appears one clock after the access cycle. That is two edges after the inputs were applied.

A burst begins at either of two start strobes. The processor start always reads. The controller start reads or writes according to the byte write enables. While neither strobe is asserted, an advance input steps a 2-bit beat count and produces an interleaved sequence in the low address bits. The sequence wraps after four beats. With advance low, the same word is accessed again, which acts as a wait state. A write can take two cycles: a processor start with the address in the first cycle, then the data and byte enables in the second cycle with no strobe. Each of the two byte enables covers nine bits. The output enable acts combinationally. The bidirectional data pins are modelled as a data input, a data output and an output-drive flag. The address width is a parameter; `AW = 16` gives the full 64K-word size.

Top module: `burst_sram_pipe`

## Requirements
- R1: `byte_we_i[0]` writes word bits 8:0 and `byte_we_i[1]` writes bits 17:9; either or both may be set. A lane whose enable is clear keeps its previous contents.
- R2: If a read access is presented before edge n, its data drives `data_o` from edge n+1 until edge n+2, with `data_oe_o` = 1 when `oe_i` = 1. Before edge n+1, `data_oe_o` does not reflect that read.
- R3: A processor start (`cpu_start_i` = 1) with `sel_i` = 1 reads the word at `addr_i`. This holds whatever the values of `byte_we_i` and `ctl_start_i`, and the start begins a new burst at that base address.
- R4: A controller start (`ctl_start_i` = 1, `cpu_start_i` = 0) with `sel_i` = 1 writes the word at `addr_i` when any bit of `byte_we_i` is set, and otherwise reads it. It also begins a new burst.
- R5: In a cycle with neither start strobe and a burst active, `adv_i` = 1 first increments a 2-bit beat count (modulo 4). The accessed address is then the base address with its two low bits XORed with the count. With `adv_i` = 0, the same address as the previous access is used. The access is a write if any `byte_we_i` bit is set, and a read otherwise.
- R6: A processor start at address A, followed by one cycle with no strobe, `adv_i` = 0 and some `byte_we_i` bits set, writes that cycle's `data_i` lanes into word A.
- R7: A start with `sel_i` = 0 performs no access and ends any burst. Until the next start with `sel_i` = 1, strobeless cycles neither read nor write, and `data_oe_o` is 0 from the edge after the deselecting cycle. `sel_i` is ignored in cycles without a start.
- R8: `oe_i` = 0 forces `data_oe_o` to 0 at once, without a clock edge. Raising `oe_i` again restores the registered drive state at once.
- R9: During a cycle whose decoded access is a write, `data_oe_o` is 0 regardless of `oe_i`.
- R10: A read of a word written by the immediately preceding access returns the newly written value.
- R11: Synchronous reset `rst` ends any burst and clears the registered strobes, write enables and output drive. After reset, `data_oe_o` is 0 and no access happens until a start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | AW | Word address, used at a start |
| cpu_start_i | input | 1 | Processor start strobe, always reads |
| ctl_start_i | input | 1 | Controller start strobe, reads or writes |
| adv_i | input | 1 | Step the burst beat count |
| sel_i | input | 1 | Chip select, sampled only at a start |
| byte_we_i | input | 2 | Byte lane write enables (bit0: 8:0, bit1: 17:9) |
| data_i | input | 18 | Write data |
| oe_i | input | 1 | Asynchronous output enable, active high |
| data_o | output | 18 | Registered read data |
| data_oe_o | output | 1 | High when the data pins are driven |

## Verification
The memory is first filled through single-cycle controller writes. It is then exercised with directed patterns:
- reads started by the processor with write enables set, which tells the two start types apart;
- single-lane writes, which separate the lanes;
- interleaved bursts with wait states and wrap, which tell advance from hold and XOR ordering from linear ordering;
- two-cycle writes;
- deselected cycles carrying write enables, which must leave memory untouched;
- write-then-read back-to-back and output-enable toggles inside a cycle.

A long seeded random mix of strobes, selects, advances, byte enables and output enable is checked cycle by cycle against a reference model of the requirements. This run is what exposes ordering faults between bursts, deselects and turnarounds.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } acc_op_e;
endpackage

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
  import burst_sram_pkg::*;
#(
  parameter int AW      = 8,
  parameter int BL_BITS = 2,
  parameter int DW      = 18,
  parameter int NB      = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr_i,
  input  logic          cpu_start_i,
  input  logic          ctl_start_i,
  input  logic          adv_i,
  input  logic          sel_i,
  input  logic [NB-1:0] byte_we_i,
  input  logic [DW-1:0] data_i,
  output acc_op_e       acc_op,
  output logic [AW-1:0] acc_addr,
  output logic [NB-1:0] acc_be,
  output logic [DW-1:0] acc_wdata
);
  // captured inputs
  logic          r_cpu, r_ctl, r_adv, r_sel;
  logic [NB-1:0] r_we;
  logic [AW-1:0] r_addr;
  logic [DW-1:0] r_din;

  // burst state
  logic               act_q;
  logic [AW-1:0]      base_q;
  logic [BL_BITS-1:0] cnt_q, cnt_nx;
  logic               load;

  always_ff @(posedge clk) begin
    if (rst) begin
      r_cpu <= 1'b0;
      r_ctl <= 1'b0;
      r_adv <= 1'b0;
      r_we  <= '0;
    end else begin
      r_cpu <= cpu_start_i;
      r_ctl <= ctl_start_i;
      r_adv <= adv_i;
      r_we  <= byte_we_i;
    end
  end

  always_ff @(posedge clk) begin
    r_addr <= addr_i;
    r_sel  <= sel_i;
    r_din  <= data_i;
  end

  always_comb begin
    load     = r_cpu | r_ctl;
    cnt_nx   = cnt_q + {{(BL_BITS-1){1'b0}}, r_adv};
    acc_addr = base_q ^ {{(AW-BL_BITS){1'b0}}, cnt_nx};
    acc_op   = OP_IDLE;
    if (load) begin
      acc_addr = r_addr;
      if (!r_sel)      acc_op = OP_IDLE;
      else if (r_cpu)  acc_op = OP_READ;
      else if (|r_we)  acc_op = OP_WRITE;
      else             acc_op = OP_READ;
    end else if (act_q) begin
      acc_op = (|r_we) ? OP_WRITE : OP_READ;
    end
    acc_be    = (acc_op == OP_WRITE) ? r_we : '0;
    acc_wdata = r_din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      cnt_q  <= '0;
      base_q <= '0;
    end else if (load) begin
      act_q  <= r_sel;
      cnt_q  <= '0;
      base_q <= r_addr;
    end else if (act_q) begin
      cnt_q  <= cnt_nx;
    end
  end

  // R5: a wait state keeps the beat count
  a_r5_hold_count: assert property (@(posedge clk) disable iff (rst)
    (act_q && !load && !r_adv) |=> (cnt_q == $past(cnt_q)));

  // R5: an advance steps the beat count by one, wrapping
  a_r5_step_count: assert property (@(posedge clk) disable iff (rst)
    (act_q && !load && r_adv) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R7: a deselecting start ends the burst
  a_r7_desel_ends: assert property (@(posedge clk) disable iff (rst)
    (load && !r_sel) |=> !act_q);
endmodule

// File: rtl/burst_sram_array.sv
module burst_sram_array #(
  parameter int AW     = 8,
  parameter int BYTE_W = 9,
  parameter int NB     = 2
) (
  input  logic                 clk,
  input  logic                 rd_en,
  input  logic [NB-1:0]        we,
  input  logic [AW-1:0]        addr,
  input  logic [BYTE_W*NB-1:0] wdata,
  output logic [BYTE_W*NB-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [BYTE_W-1:0] mem [DEPTH];
    logic [BYTE_W-1:0] lane_q;

    always_ff @(posedge clk) begin
      if (we[g]) mem[addr] <= wdata[g*BYTE_W +: BYTE_W];
    end

    always_ff @(posedge clk) begin
      if (rd_en) lane_q <= mem[addr];
    end

    assign rdata[g*BYTE_W +: BYTE_W] = lane_q;
  end
endmodule

// File: rtl/burst_sram_pipe.sv
module burst_sram_pipe
  import burst_sram_pkg::*;
#(
  parameter int AW      = 8,
  parameter int BYTE_W  = 9,
  parameter int NB      = 2,
  parameter int BL_BITS = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [AW-1:0]        addr_i,
  input  logic                 cpu_start_i,
  input  logic                 ctl_start_i,
  input  logic                 adv_i,
  input  logic                 sel_i,
  input  logic [NB-1:0]        byte_we_i,
  input  logic [BYTE_W*NB-1:0] data_i,
  input  logic                 oe_i,
  output logic [BYTE_W*NB-1:0] data_o,
  output logic                 data_oe_o
);
  localparam int DW = BYTE_W * NB;

  acc_op_e       acc_op;
  logic [AW-1:0] acc_addr;
  logic [NB-1:0] acc_be;
  logic [DW-1:0] acc_wdata;
  logic          drive_q;

  burst_sram_ctrl #(.AW(AW), .BL_BITS(BL_BITS), .DW(DW), .NB(NB)) i_ctrl (
    .clk        (clk),
    .rst        (rst),
    .addr_i     (addr_i),
    .cpu_start_i(cpu_start_i),
    .ctl_start_i(ctl_start_i),
    .adv_i      (adv_i),
    .sel_i      (sel_i),
    .byte_we_i  (byte_we_i),
    .data_i     (data_i),
    .acc_op     (acc_op),
    .acc_addr   (acc_addr),
    .acc_be     (acc_be),
    .acc_wdata  (acc_wdata)
  );

  burst_sram_array #(.AW(AW), .BYTE_W(BYTE_W), .NB(NB)) i_array (
    .clk  (clk),
    .rd_en(acc_op == OP_READ),
    .we   (acc_be),
    .addr (acc_addr),
    .wdata(acc_wdata),
    .rdata(data_o)
  );

  always_ff @(posedge clk) begin
    if (rst) drive_q <= 1'b0;
    else     drive_q <= (acc_op == OP_READ);
  end

  assign data_oe_o = oe_i & drive_q & (acc_op != OP_WRITE);

  // R7: no access in a cycle leaves the pins undriven after the edge
  a_r7_idle_hiz: assert property (@(posedge clk) disable iff (rst)
    (acc_op == OP_IDLE) |=> !data_oe_o);

  // R10: full-word write then read of the same word returns the new value
  a_r10_rd_after_wr: assert property (@(posedge clk) disable iff (rst)
    (acc_op == OP_READ && $past(acc_op) == OP_WRITE && $past(acc_be) == {NB{1'b1}}
     && acc_addr == $past(acc_addr))
    |=> (data_o == $past(acc_wdata, 2)));
endmodule

// File: tb/test_burst_sram_pipe.sv
module test_burst_sram_pipe;
  localparam int AW    = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] addr_i;
  logic          cpu_start_i, ctl_start_i, adv_i, sel_i, oe_i;
  logic [1:0]    byte_we_i;
  logic [17:0]   data_i;
  logic [17:0]   data_o;
  logic          data_oe_o;

  int n_tests = 0;
  int n_fail  = 0;
  string tag = "R11";

  burst_sram_pipe #(.AW(AW)) i_burst_sram_pipe (
    .clk(clk), .rst(rst), .addr_i(addr_i), .cpu_start_i(cpu_start_i),
    .ctl_start_i(ctl_start_i), .adv_i(adv_i), .sel_i(sel_i),
    .byte_we_i(byte_we_i), .data_i(data_i), .oe_i(oe_i),
    .data_o(data_o), .data_oe_o(data_oe_o)
  );

  always #5 clk = ~clk;

  // reference model state
  bit        m_cpu, m_ctl, m_adv, m_sel;
  bit [1:0]  m_we;
  int        m_addr;
  bit [17:0] m_din;
  bit        m_act, m_drive;
  int        m_base, m_cnt;
  bit [17:0] m_rdata;
  bit [17:0] ref_mem [DEPTH];

  // 0 idle, 1 read, 2 write
  function automatic int mop(output int a);
    int c;
    a = 0;
    if (m_cpu || m_ctl) begin
      a = m_addr;
      if (!m_sel) return 0;
      if (m_cpu)  return 1;
      return (m_we != 0) ? 2 : 1;
    end
    if (m_act) begin
      c = (m_cnt + int'(m_adv)) & 3;
      a = m_base ^ c;
      return (m_we != 0) ? 2 : 1;
    end
    return 0;
  endfunction

  task automatic model_edge();
    int a, op;
    if (rst) begin
      m_act = 0; m_cnt = 0; m_base = 0; m_drive = 0;
      m_cpu = 0; m_ctl = 0; m_adv = 0; m_we = 0;
    end else begin
      op = mop(a);
      if (op == 1) m_rdata = ref_mem[a];
      if (op == 2) begin
        if (m_we[0]) ref_mem[a][8:0]  = m_din[8:0];
        if (m_we[1]) ref_mem[a][17:9] = m_din[17:9];
      end
      m_drive = (op == 1);
      if (m_cpu || m_ctl) begin
        m_act = m_sel; m_base = m_addr; m_cnt = 0;
      end else if (m_act) begin
        m_cnt = (m_cnt + int'(m_adv)) & 3;
      end
      m_cpu = cpu_start_i; m_ctl = ctl_start_i; m_adv = adv_i; m_we = byte_we_i;
    end
    m_addr = int'(addr_i); m_sel = sel_i; m_din = data_i;
  endtask

  task automatic chk(string t, logic [17:0] act, logic [17:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("[TB] FAIL %s: actual %h expected %h at %0t", t, act, exp, $time);
    end
  endtask

  function automatic bit exp_en();
    int a;
    return oe_i && m_drive && (mop(a) != 2);
  endfunction

  task automatic check_outputs();
    bit e;
    e = exp_en();
    chk(tag, {17'd0, data_oe_o}, {17'd0, e});
    if (e) chk(tag, data_o, m_rdata);
  endtask

  task automatic step(bit cpu, bit ctl, bit adv, bit sel, bit [1:0] we,
                      int a, bit [17:0] d, bit oe);
    @(negedge clk);
    cpu_start_i = cpu; ctl_start_i = ctl; adv_i = adv; sel_i = sel;
    byte_we_i = we; addr_i = AW'(a); data_i = d; oe_i = oe;
    @(posedge clk);
    model_edge();
    #1;
    check_outputs();
  endtask

  task automatic desel();
    step(0, 1, 0, 0, 2'b00, 0, 18'h0, 1);
  endtask

  task automatic rd(int a);
    step(0, 1, 0, 1, 2'b00, a, 18'h0, 1);
  endtask

  task automatic oe_probe();
    oe_i = 1'b0;
    #1;
    chk("R8", {17'd0, data_oe_o}, 18'd0);
    oe_i = 1'b1;
    #1;
    chk("R8", {17'd0, data_oe_o}, {17'd0, exp_en()});
  endtask

  function automatic bit [17:0] pat(int a);
    return 18'((a * 37) ^ 18'h2A5A5);
  endfunction

  initial begin
    #1_000_000;
    n_fail++;
    $display("[TB] FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1;
    cpu_start_i = 0; ctl_start_i = 0; adv_i = 0; sel_i = 0;
    byte_we_i = 0; addr_i = '0; data_i = '0; oe_i = 1'b1;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 2'b00, 0, 18'h0, 1);
    rst = 1'b0;
    // R11: after reset nothing drives and no access starts
    tag = "R11";
    step(0, 0, 1, 1, 2'b11, 3, 18'h1, 1);
    step(0, 0, 1, 1, 2'b00, 3, 18'h1, 1);
    chk("R11", {17'd0, data_oe_o}, 18'd0);

    // R4: fill memory with controller writes
    tag = "R4";
    for (int a = 0; a < DEPTH; a++) step(0, 1, 0, 1, 2'b11, a, pat(a), 1);
    rd(17); desel(); desel();
    rd(200); rd(201); desel(); desel();

    // R3: processor start reads even with enables and controller strobe set
    tag = "R3";
    step(1, 0, 0, 1, 2'b11, 5, 18'h3FFFF, 1);
    step(1, 1, 0, 1, 2'b11, 6, 18'h3FFFF, 1);
    desel(); desel();
    rd(5); rd(6); desel(); desel();

    // R2: latency of the output register
    tag = "R2";
    step(0, 1, 0, 1, 2'b00, 9, 18'h0, 1);
    chk("R2", {17'd0, data_oe_o}, 18'd0);
    desel();
    chk("R2", {17'd0, data_oe_o}, 18'd1);
    chk("R2", data_o, pat(9));
    desel();

    // R1: single-lane writes
    tag = "R1";
    step(0, 1, 0, 1, 2'b01, 10, 18'h3FFFF, 1);
    step(0, 1, 0, 1, 2'b10, 11, 18'h00000, 1);
    rd(10); rd(11); desel();
    chk("R1", data_o, {pat(11)[17:9] & 9'h000, pat(11)[8:0]});
    desel();

    // R5: interleaved burst read with wait states and wrap
    tag = "R5";
    step(1, 0, 0, 1, 2'b00, 8'h21, 18'h0, 1);
    step(0, 0, 1, 0, 2'b00, 0, 18'h0, 1);
    step(0, 0, 0, 0, 2'b00, 0, 18'h0, 1);
    step(0, 0, 1, 0, 2'b00, 0, 18'h0, 1);
    step(0, 0, 1, 0, 2'b00, 0, 18'h0, 1);
    step(0, 0, 1, 0, 2'b00, 0, 18'h0, 1);
    desel();
    chk("R5", data_o, pat(8'h21));
    desel();
    // burst write then burst read back
    step(0, 1, 0, 1, 2'b11, 8'h42, 18'h11111, 1);
    step(0, 0, 1, 1, 2'b11, 0, 18'h22222, 1);
    step(0, 0, 1, 1, 2'b11, 0, 18'h33333, 1);
    step(0, 0, 1, 1, 2'b11, 0, 18'h04444, 1);
    step(0, 1, 0, 1, 2'b00, 8'h42, 18'h0, 1);
    for (int i = 0; i < 4; i++) step(0, 0, 1, 1, 2'b00, 0, 18'h0, 1);
    desel(); desel();

    // R6: two-cycle write from a processor start
    tag = "R6";
    step(1, 0, 0, 1, 2'b00, 8'h30, 18'h0, 1);
    step(0, 0, 0, 0, 2'b11, 8'h99, 18'h2BEEF, 1);
    desel();
    rd(8'h30); desel();
    chk("R6", data_o, 18'h2BEEF);
    desel();

    // R7: deselected start then strobeless writes leave memory untouched
    tag = "R7";
    step(0, 1, 0, 0, 2'b11, 7, 18'h3AAAA, 1);
    step(0, 0, 0, 1, 2'b11, 7, 18'h3BBBB, 1);
    step(0, 0, 1, 1, 2'b11, 7, 18'h3CCCC, 1);
    chk("R7", {17'd0, data_oe_o}, 18'd0);
    rd(7); desel();
    chk("R7", data_o, pat(7));
    desel();

    // R8: asynchronous output enable inside a cycle
    tag = "R8";
    rd(20);
    step(0, 0, 0, 1, 2'b00, 0, 18'h0, 1);
    oe_probe();
    step(0, 0, 0, 1, 2'b00, 0, 18'h0, 0);
    oe_probe();
    desel(); desel();

    // R9 and R10: read, write turnaround, read back
    tag = "R9";
    rd(30);
    step(0, 1, 0, 1, 2'b11, 30, 18'h15A5A, 1);
    chk("R9", {17'd0, data_oe_o}, 18'd0);
    tag = "R10";
    rd(30); desel();
    chk("R10", data_o, 18'h15A5A);
    desel();

    // R5: seeded random mix against the reference model
    tag = "R5";
    for (int i = 0; i < 3000; i++) begin
      step($urandom_range(0, 99) < 12, $urandom_range(0, 99) < 15,
           $urandom_range(0, 1) == 1, $urandom_range(0, 99) < 88,
           2'($urandom_range(0, 3) & ($urandom_range(0, 2) == 0 ? 3 : 0)),
           int'($urandom_range(0, DEPTH - 1)), 18'($urandom),
           $urandom_range(0, 99) < 85);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule